// File: doc/BRIEF.md
# Input Change Interrupt with Deferred Release

This block watches a 40-bit input word, split into five 8-bit banks numbered 0 to 4. It compares the word against a reference copy taken at the most recent read of each bank. Any unmasked bit that differs from its reference pulls the active-low interrupt line low. If a bit returns to its reference value before its bank is read, it stops requesting the interrupt without any read.

A bus front end reads the banks in a burst: it pulses `rd_en` with a bank index for each bank it reads, then pulses `burst_end`. Reading a bank copies that bank's current inputs into the reference and returns those inputs on `rd_data` one cycle later. The first read of a burst records which other banks hold a pending change at that moment. The interrupt then stays low until each recorded bank has been read, even if the changed bits return to their old values in the meantime. So a host that starts reading at bank 0 cannot clear the request by reading only part of the changed banks. Ending the burst drops the recorded set, and from then on the line follows the live differences only.

Top module: `input_change_irq`

## Requirements
- R1: While `rst_n` is low, the reference is loaded from `pins`. After reset, `int_n` is 1 and `rd_data` is 0, whatever value `pins` holds.
- R2: In the same cycle that an unmasked bit of `pins` differs from its reference bit, `int_n` is 0.
- R3: A bit whose `mask` bit is 1 never drives `int_n` low by itself. With every mask bit set and no burst debt, `int_n` is 1.
- R4: A read of bank b (0 to 4) is `rd_en` = 1 with `rd_bank` = b at a clock edge. Bank b is `pins[8b+7:8b]`. At that edge the read copies bank b of `pins` into the reference, and from the next cycle `rd_data` shows that value. A change after the edge is measured against the new reference.
- R5: Outside a burst, if a changed bit returns to its reference value, `int_n` goes back to 1 in the same cycle, with no read.
- R6: The first valid read of a burst records every other bank that has an unmasked difference at that edge. `int_n` stays 0 until each recorded bank has been read in the burst, even if its differences disappear first.
- R7: At a clock edge where `burst_end` is 1, the recorded bank set is cleared and the burst closes. The next valid read starts a new burst. After this edge `int_n` depends only on live differences.
- R8: A read with `rd_bank` of 5 to 7 leaves the reference and the recorded set unchanged, does not start a burst, and loads 0 into `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pins | input | 40 | Synchronized input values, bank b in bits 8b+7..8b |
| mask | input | 40 | Per-bit mask; 1 excludes the bit from the interrupt |
| rd_en | input | 1 | Bank read strobe |
| rd_bank | input | 3 | Index of the bank being read |
| burst_end | input | 1 | Marks the end of a read burst |
| int_n | output | 1 | Interrupt, active low (1 means released) |
| rd_data | output | 8 | Reference value captured by the last read |

## Verification
The bench uses the two-change example: bank 2 bit 4 and bank 4 bit 7 change, and a burst starts at bank 0. The line must stay low after bank 2 is read and after bank 4's bit reverts, and must release only when bank 4 is read. A design that cleared on the first read, or that released early on the revert, would raise `int_n` too soon. The bench also checks masked-only changes, which a mask applied backwards would report. It checks a burst that ends before its debt is paid, where a design that kept the debt would leave the line stuck low. It checks reads of banks 5 to 7, which a design without a range check would let corrupt the reference or start a burst. Random traffic covers reads that land in the same cycle as new changes.

// File: rtl/input_change_irq.sv
module input_change_irq #(
  parameter int BANKS  = 5,
  parameter int BANK_W = 8,
  localparam int W     = BANKS * BANK_W,
  localparam int IDX_W = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      pins,
  input  logic [W-1:0]      mask,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_bank,
  input  logic              burst_end,
  output logic              int_n,
  output logic [BANK_W-1:0] rd_data
);

  logic [W-1:0]      ref_q;
  logic [BANKS-1:0]  owed_q;
  logic              in_burst_q;
  logic [BANK_W-1:0] rd_data_q;
  logic [BANKS-1:0]  bank_pend;
  logic [BANKS-1:0]  rd_sel;

  wire [W-1:0] diff  = (pins ^ ref_q) & ~mask;
  wire         rd_ok = rd_en && (int'(rd_bank) < BANKS);

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    assign bank_pend[g] = |diff[g*BANK_W +: BANK_W];
    assign rd_sel[g]    = rd_ok && (int'(rd_bank) == g);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q      <= pins;
      owed_q     <= '0;
      in_burst_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      for (int b = 0; b < BANKS; b++)
        if (rd_sel[b]) ref_q[b*BANK_W +: BANK_W] <= pins[b*BANK_W +: BANK_W];
      if (rd_en)
        rd_data_q <= rd_ok ? pins[int'(rd_bank)*BANK_W +: BANK_W] : '0;
      if (burst_end) begin
        owed_q     <= '0;
        in_burst_q <= 1'b0;
      end else if (rd_ok) begin
        owed_q     <= (in_burst_q ? owed_q : bank_pend) & ~rd_sel;
        in_burst_q <= 1'b1;
      end
    end
  end

  assign int_n   = !((|diff) || (|owed_q));
  assign rd_data = rd_data_q;

endmodule

module input_change_irq_chk #(
  parameter int BANKS  = 5,
  parameter int BANK_W = 8,
  localparam int W     = BANKS * BANK_W,
  localparam int IDX_W = $clog2(BANKS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [W-1:0]      pins,
  input logic [W-1:0]      mask,
  input logic              rd_en,
  input logic [IDX_W-1:0]  rd_bank,
  input logic              burst_end,
  input logic              int_n,
  input logic [BANK_W-1:0] rd_data,
  input logic [W-1:0]      ref_q,
  input logic [BANKS-1:0]  owed_q
);

  wire              good_rd  = rd_en && (int'(rd_bank) < BANKS);
  wire              bad_rd   = rd_en && (int'(rd_bank) >= BANKS);
  wire [BANK_W-1:0] sel_pins = good_rd ? pins[int'(rd_bank)*BANK_W +: BANK_W] : '0;

  AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((&mask) && (owed_q == '0)) |-> int_n); // R3
  AST_READ_RETURNS_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    good_rd |=> (rd_data == $past(sel_pins))); // R4
  AST_DEBT_HOLDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (owed_q != '0) |-> !int_n); // R6
  AST_BURST_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    burst_end |=> (owed_q == '0)); // R7
  AST_BAD_BANK_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_rd && !burst_end) |=> ((rd_data == '0) && $stable(ref_q) && $stable(owed_q))); // R8

endmodule

bind input_change_irq input_change_irq_chk #(.BANKS(BANKS), .BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pins(pins), .mask(mask), .rd_en(rd_en),
  .rd_bank(rd_bank), .burst_end(burst_end), .int_n(int_n), .rd_data(rd_data),
  .ref_q(ref_q), .owed_q(owed_q)
);

// File: tb/input_change_irq_bench.sv
module input_change_irq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [39:0] pins, mask;
  logic        rd_en, burst_end;
  logic [2:0]  rd_bank;
  logic        int_n;
  logic [7:0]  rd_data;

  logic [39:0] ref_m;
  logic [4:0]  owed_m;
  logic        inb_m;
  logic [7:0]  rdd_m;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  input_change_irq u_input_change_irq (
    .clk(clk), .rst_n(rst_n), .pins(pins), .mask(mask), .rd_en(rd_en),
    .rd_bank(rd_bank), .burst_end(burst_end), .int_n(int_n), .rd_data(rd_data)
  );

  function automatic logic exp_int();
    return !((|((pins ^ ref_m) & ~mask)) || (|owed_m));
  endfunction

  task automatic chk(input logic [39:0] act, input logic [39:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic step(input logic [39:0] p, input logic [39:0] m, input logic re,
                      input logic [2:0] rb, input logic be, input string tag);
    logic [39:0] d;
    logic [4:0] bp, sel;
    logic ok;
    @(negedge clk);
    pins = p; mask = m; rd_en = re; rd_bank = rb; burst_end = be;
    #1;
    chk(int_n, exp_int(), {tag, " int_n"});
    chk(rd_data, rdd_m, "R4 rd_data");
    d = (p ^ ref_m) & ~m;
    for (int b = 0; b < 5; b++) bp[b] = |d[b*8 +: 8];
    ok = re && (rb < 3'd5);
    sel = ok ? (5'd1 << rb) : 5'd0;
    @(posedge clk);
    if (ok) ref_m[rb*8 +: 8] = p[rb*8 +: 8];
    if (re) rdd_m = ok ? p[rb*8 +: 8] : 8'd0;
    if (be) begin owed_m = '0; inb_m = 0; end
    else if (ok) begin owed_m = (inb_m ? owed_m : bp) & ~sel; inb_m = 1; end
    #1 rd_en = 0; burst_end = 0;
  endtask

  task automatic peek(input logic exp, input string tag);
    @(negedge clk); #1;
    chk(int_n, exp, tag);
    chk(int_n, exp_int(), {tag, " model"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [39:0] base, p, m;
    void'($urandom(32'd4242));
    rst_n = 0; pins = 40'hA5_3C_0F_F0_99; mask = '0;
    rd_en = 0; rd_bank = 0; burst_end = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    ref_m = pins; owed_m = '0; inb_m = 0; rdd_m = '0;
    #1;
    chk(int_n, 1'b1, "R1 int_n after reset");
    chk(rd_data, 8'h00, "R1 rd_data after reset");
    base = pins;

    step(base ^ 40'h1, '0, 0, 0, 0, "R2 pre");
    peek(1'b0, "R2 single unmasked change");
    step(base ^ 40'h1, 40'h1, 0, 0, 0, "R3 pre");
    peek(1'b1, "R3 masked change quiet");
    step(base ^ 40'h1, '0, 0, 0, 0, "R5 pre");
    step(base, '0, 0, 0, 0, "R5 pre2");
    peek(1'b1, "R5 revert releases");

    p = base ^ (40'h10 << 16) ^ (40'h80 << 32);
    step(p, '0, 1, 3'd0, 0, "R6 read b0");
    peek(1'b0, "R6 after bank0");
    step(p, '0, 1, 3'd1, 0, "R6 read b1");
    step(p, '0, 1, 3'd2, 0, "R6 read b2");
    peek(1'b0, "R6 held after bank2");
    chk(rd_data, p[23:16], "R4 bank2 data");
    step(p ^ (40'h80 << 32), '0, 1, 3'd3, 0, "R6 read b3");
    peek(1'b0, "R6 held after bank4 revert");
    step(p ^ (40'h80 << 32), '0, 1, 3'd4, 1, "R6 read b4");
    peek(1'b1, "R6 released after bank4");

    base = pins;
    step(base ^ (40'h2 << 24), '0, 1, 3'd0, 0, "R7 start");
    step(base, '0, 0, 0, 0, "R7 revert");
    peek(1'b0, "R7 debt holds before end");
    step(base, '0, 0, 0, 1, "R7 end");
    peek(1'b1, "R7 released by burst end");

    step(base ^ 40'h4, '0, 1, 3'd6, 0, "R8 bad read");
    peek(1'b0, "R8 reference untouched");
    chk(rd_data, 8'h00, "R8 rd_data zero");
    step(base ^ 40'h4, '0, 0, 0, 1, "R8 no burst");
    peek(1'b0, "R8 no burst started");

    for (int i = 0; i < 600; i++) begin
      p = pins;
      if ($urandom_range(2) == 0) p[$urandom_range(39)] ^= 1'b1;
      if ($urandom_range(5) == 0) p = ref_m;
      m = ($urandom_range(3) == 0) ? {$urandom(), $urandom()} : 40'h0;
      step(p, m, ($urandom_range(2) != 0), 3'($urandom_range(7)),
           ($urandom_range(6) == 0), "R2 R6 R7 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule